// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Host

The block is a serial peripheral interface (SPI) host that a processor drives through seven 8-bit registers: a control register, a configuration/status register, four data byte registers and a manual select register. A transfer starts when software writes the most significant data byte. The engine then sends the top 8, 16, 24 or 32 bits of the 32-bit data window on MOSI and writes the bits it samples on MISO back into the same bit positions. Software polls the busy bit and reads the received word once busy drops.

Clock polarity, clock phase, bit order and one of four serial clock rates can each be chosen. These settings are captured when a frame starts. One of eight active-low select lines can be driven by the engine for the length of each frame, or held from a register bit. An active-low interrupt input shared by the attached devices is synchronized, shown in the status register and, when enabled, sent to one of four interrupt outputs.

Register addresses: 0 control, 1 configuration/status, 2 to 5 data bytes 0 to 3 (byte 3 is bits 31..24), 6 manual select. Engine states: IDLE, SETUP (select asserted, one half period before the first clock edge), SHIFT (2N clock edges for an N-bit frame) and HOLD (one half period after the last edge). The transitions are IDLE to SETUP on a start, SETUP to SHIFT on a half-period tick, SHIFT to HOLD on the tick of the last edge, and HOLD to IDLE on the next tick.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, every register reads 0, all select lines are high, SCLK and MOSI are low, and every interrupt output is low.
- R2: The control register (bit 7 polarity, bit 6 phase, bits 5:4 length code, bit 3 manual select, bits 2:0 line number) reads back as written. In the configuration register, bits 7:6 (interrupt route), 5:4 (rate code), 3 (interrupt enable) and 2 (LSB first) read back as written. Bits 1 (interrupt seen) and 0 (busy) are read-only.
- R3: When idle, a write to data byte 3 (address 5) starts a frame. Busy reads 1 from the next cycle until the received word is readable, and then reads 0.
- R4: Length code 00, 01, 10 or 11 gives 8, 16, 24 or 32 leading SCLK edges. The frame uses the top bytes of the window, from data byte 3 downwards.
- R5: With bit 2 of the configuration register at 0, bit 31 is sent first and lower positions follow. With it at 1, the lowest bit of the frame (bit 32-N) is sent first and higher positions follow.
- R6: SCLK idles at the polarity bit. With phase 0, MOSI is valid before the first edge and both sides sample on leading edges. With phase 1, data changes on leading edges and is sampled on trailing edges.
- R7: Each MISO bit replaces the data bit at the position sent in the same slot. Bit positions below the frame keep their values.
- R8: Rate code 00, 01, 10 or 11 gives a serial clock of 1, 2, 4 or 8 MHz. For the default 48 MHz system clock, these are half periods of 24, 12, 6 and 3 cycles.
- R9: In automatic mode, only the numbered select line goes low. It falls once before the first edge and rises once after the last edge.
- R10: In manual mode, the numbered select line is low exactly while bit 0 of the manual select register is 1, and it does not change during a frame.
- R11: While busy, writes to any data byte register are ignored: no second frame starts and the stored word is not changed.
- R12: Configuration bit 1 reads 1 while the device interrupt input is low, after synchronization. Interrupt output k is high only when that input is asserted, the enable bit is 1 and the route field equals k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SEL_LINES | Active-low select lines |
| dev_int_n | input | 1 | Active-low shared device interrupt |
| irq_out | output | IRQ_LINES | Routed interrupt outputs |

## Verification
The assertions assume that MISO is stable at the clock edge on which the engine samples it. The bench's device model changes MISO only on the opposite SCLK edge, so this holds. They also assume that SEL_LINES and IRQ_LINES do not exceed what the 3-bit line field and the 2-bit route field can name, and the bench keeps the defaults. The device interrupt is asynchronous, so the bench holds each level for several cycles before it looks at the status bit or the outputs.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;

    localparam int REG_AW  = 3;
    localparam int WIN_W   = 32;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = WIN_W / BYTE_W;
    localparam int POS_W   = $clog2(WIN_W);

    localparam logic [REG_AW-1:0] ADR_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] ADR_CONF = 3'd1;
    localparam logic [REG_AW-1:0] ADR_DAT0 = 3'd2;
    localparam logic [REG_AW-1:0] ADR_DAT3 = 3'd5;
    localparam logic [REG_AW-1:0] ADR_MSEL = 3'd6;

    typedef struct packed {
        logic       pol;
        logic       pha;
        logic [1:0] len;
        logic       manual;
        logic [2:0] line;
    } ctrl_t;

    typedef struct packed {
        logic [1:0] route;
        logic [1:0] rate;
        logic       irq_en;
        logic       lsb_first;
    } conf_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } eng_state_e;

endpackage

// File: rtl/spi_host_regs.sv
`timescale 1ns/1ps
module spi_host_regs
    import spi_host_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        addr,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [BYTE_W-1:0]        rd_data,
    input  logic                     eng_run,
    input  logic                     done,
    input  logic [WIN_W-1:0]         rx_word,
    input  logic                     dev_int,
    output ctrl_t                    ctrl_q,
    output conf_t                    conf_q,
    output logic                     msel_q,
    output logic [WIN_W-1:0]         word_q,
    output logic                     start,
    output logic                     busy
);

    logic [N_BYTES-1:0][BYTE_W-1:0] data_q;
    logic                           start_q;

    assign busy   = start_q | eng_run | done;
    assign start  = start_q;
    assign word_q = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            conf_q  <= '0;
            msel_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= wr_en && !busy && (addr == ADR_DAT3);
            if (wr_en && addr == ADR_CTRL) ctrl_q <= ctrl_t'(wr_data);
            if (wr_en && addr == ADR_CONF) conf_q <= conf_t'(wr_data[7:2]);
            if (wr_en && addr == ADR_MSEL) msel_q <= wr_data[0];
        end
    end

    generate
        for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
            localparam logic [REG_AW-1:0] MY_ADR = ADR_DAT0 + REG_AW'(b);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    data_q[b] <= '0;
                end else if (done) begin
                    data_q[b] <= rx_word[b*BYTE_W +: BYTE_W];
                end else if (wr_en && !busy && addr == MY_ADR) begin
                    data_q[b] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (addr == ADR_CTRL) begin
            rd_data = ctrl_q;
        end else if (addr == ADR_CONF) begin
            rd_data = {conf_q, dev_int, busy};
        end else if (addr == ADR_MSEL) begin
            rd_data = {7'd0, msel_q};
        end else if (addr >= ADR_DAT0 && addr <= ADR_DAT3) begin
            rd_data = data_q[2'(addr - ADR_DAT0)];
        end
    end

endmodule

// File: rtl/spi_host_clkgen.sv
`timescale 1ns/1ps
module spi_host_clkgen #(
    parameter int SYS_HZ  = 48_000_000,
    parameter int BASE_HZ = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int MAX_HALF = SYS_HZ / (2 * BASE_HZ);
    localparam int CW       = $clog2(MAX_HALF + 1);

    logic [3:0][CW-1:0] half_tbl;
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      lim;

    generate
        for (genvar g = 0; g < 4; g++) begin : g_rate
            assign half_tbl[g] = CW'(SYS_HZ / (2 * (BASE_HZ << g)));
        end
    endgenerate

    assign lim  = half_tbl[rate] - CW'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/spi_host_engine.sv
`timescale 1ns/1ps
module spi_host_engine
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  ctrl_t             ctrl,
    input  conf_t             conf,
    input  logic [WIN_W-1:0]  word_in,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              run,
    output logic [1:0]        rate_q,
    output logic              done,
    output logic [WIN_W-1:0]  rx_word
);

    eng_state_e       state_q, state_d;
    logic             pha_q, lsb_q;
    logic [1:0]       len_q;
    logic [WIN_W-1:0] w_q;
    logic [POS_W-1:0] pos_q;
    logic [5:0]       edge_q;
    logic [5:0]       nbits, nbits_in;
    logic [6:0]       edges_total;
    logic             last_edge;
    logic             sample_edge;
    logic [POS_W-1:0] pos0;

    assign nbits       = {1'b0, len_q, 3'b000} + 6'd8;
    assign nbits_in    = {1'b0, ctrl.len, 3'b000} + 6'd8;
    assign edges_total = {nbits, 1'b0};
    assign last_edge   = ({1'b0, edge_q} == edges_total - 7'd1);
    assign sample_edge = (edge_q[0] == pha_q);
    assign pos0        = conf.lsb_first ? POS_W'(6'd32 - nbits_in) : POS_W'(WIN_W - 1);
    assign run         = (state_q != ST_IDLE);
    assign rx_word     = w_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SETUP;
            ST_SETUP: if (tick) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) state_d = ST_HOLD;
            ST_HOLD:  if (tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk   <= 1'b0;
            mosi   <= 1'b0;
            done   <= 1'b0;
            pha_q  <= 1'b0;
            lsb_q  <= 1'b0;
            len_q  <= '0;
            rate_q <= '0;
            w_q    <= '0;
            pos_q  <= '0;
            edge_q <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sclk <= ctrl.pol;
                    if (start) begin
                        pha_q  <= ctrl.pha;
                        len_q  <= ctrl.len;
                        lsb_q  <= conf.lsb_first;
                        rate_q <= conf.rate;
                        w_q    <= word_in;
                        pos_q  <= pos0;
                        edge_q <= '0;
                        mosi   <= word_in[pos0];
                    end
                end
                ST_SETUP: begin
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk   <= ~sclk;
                        edge_q <= edge_q + 6'd1;
                        if (sample_edge) begin
                            w_q[pos_q] <= miso;
                            pos_q      <= lsb_q ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
                        end else if (!(last_edge && !pha_q)) begin
                            mosi <= w_q[pos_q];
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) done <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_host_irq.sv
`timescale 1ns/1ps
module spi_host_irq #(
    parameter int IRQ_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dev_int_n,
    input  logic                 irq_en,
    input  logic [1:0]           route,
    output logic                 dev_int,
    output logic [IRQ_LINES-1:0] irq_out
);

    logic [1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], dev_int_n};
    end

    assign dev_int = ~sync_q[1];

    generate
        for (genvar k = 0; k < IRQ_LINES; k++) begin : g_irq
            assign irq_out[k] = irq_en && dev_int && (route == 2'(k));
        end
    endgenerate

endmodule

// File: rtl/spi_host_ctrl.sv
`timescale 1ns/1ps
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int SYS_HZ    = 48_000_000,
    parameter int SEL_LINES = 8,
    parameter int IRQ_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           addr,
    input  logic [7:0]           wr_data,
    output logic [7:0]           rd_data,
    output logic                 sclk,
    output logic                 mosi,
    input  logic                 miso,
    output logic [SEL_LINES-1:0] ss_n,
    input  logic                 dev_int_n,
    output logic [IRQ_LINES-1:0] irq_out
);

    ctrl_t            ctrl_q;
    conf_t            conf_q;
    logic             msel_q;
    logic [WIN_W-1:0] word_q;
    logic [WIN_W-1:0] rx_word;
    logic             start_pulse;
    logic             busy_all;
    logic             eng_run;
    logic             eng_done;
    logic             tick;
    logic [1:0]       rate_q;
    logic             dev_int;
    logic             irq_en_q;

    assign irq_en_q = conf_q.irq_en;

    spi_host_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .eng_run (eng_run),
        .done    (eng_done),
        .rx_word (rx_word),
        .dev_int (dev_int),
        .ctrl_q  (ctrl_q),
        .conf_q  (conf_q),
        .msel_q  (msel_q),
        .word_q  (word_q),
        .start   (start_pulse),
        .busy    (busy_all)
    );

    spi_host_clkgen #(.SYS_HZ(SYS_HZ)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_run),
        .rate  (rate_q),
        .tick  (tick)
    );

    spi_host_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_pulse),
        .tick    (tick),
        .ctrl    (ctrl_q),
        .conf    (conf_q),
        .word_in (word_q),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .run     (eng_run),
        .rate_q  (rate_q),
        .done    (eng_done),
        .rx_word (rx_word)
    );

    spi_host_irq #(.IRQ_LINES(IRQ_LINES)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_int_n (dev_int_n),
        .irq_en    (conf_q.irq_en),
        .route     (conf_q.route),
        .dev_int   (dev_int),
        .irq_out   (irq_out)
    );

    generate
        for (genvar i = 0; i < SEL_LINES; i++) begin : g_sel
            assign ss_n[i] = !((ctrl_q.line == 3'(i)) &&
                               (ctrl_q.manual ? msel_q : eng_run));
        end
    endgenerate

endmodule

// File: rtl/spi_host_ctrl_chk.sv
`timescale 1ns/1ps
module spi_host_ctrl_chk #(
    parameter int SEL_LINES = 8,
    parameter int IRQ_LINES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sclk,
    input logic [SEL_LINES-1:0] ss_n,
    input logic [IRQ_LINES-1:0] irq_out,
    input logic                 busy,
    input logic                 eng_run,
    input logic                 start,
    input logic                 pol,
    input logic                 irq_en,
    input logic                 manual
);

    AST_ONE_SELECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ss_n) <= 1); // R9

    AST_AUTO_SELECT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && !(&ss_n)) |-> busy); // R9

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_run && $past(!eng_run)) |-> (sclk == $past(pol))); // R6

    AST_NO_RESTART_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !eng_run); // R11

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R3

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> irq_en); // R12

    AST_IRQ_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out)); // R12

endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.SEL_LINES(SEL_LINES), .IRQ_LINES(IRQ_LINES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .ss_n    (ss_n),
    .irq_out (irq_out),
    .busy    (busy_all),
    .eng_run (eng_run),
    .start   (start_pulse),
    .pol     (ctrl_q.pol),
    .irq_en  (irq_en_q),
    .manual  (ctrl_q.manual)
);

// File: tb/spi_host_ctrl_bench.sv
`timescale 1ns/1ps
module spi_host_ctrl_bench;

    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       sclk, mosi;
    logic       miso = 1'b0;
    logic [7:0] ss_n;
    logic       dev_int_n = 1'b1;
    logic [3:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_NS/2) clk = ~clk;

    spi_host_ctrl u_spi_host_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
        .dev_int_n(dev_int_n), .irq_out(irq_out)
    );

    // device model
    logic        slv_pol = 1'b0, slv_pha = 1'b0, mon = 1'b0;
    logic [31:0] pat = '0, cap = '0;
    int          k = 0, lead = 0, ss_chg = 0, gmin = 0, gmax = 0;
    logic [7:0]  ss_or = '0;
    longint      last_t = 0;
    bit          have_last = 0;

    always @(sclk) begin
        if (mon) begin
            if (have_last) begin
                int g;
                g = int'(($time - last_t) / CLK_NS);
                if (g < gmin) gmin = g;
                if (g > gmax) gmax = g;
            end
            last_t = $time;
            have_last = 1;
            if (sclk !== slv_pol) begin
                lead++;
                if (!slv_pha) begin
                    if (k < 32) cap[k] = mosi;
                end else begin
                    if (k < 32) miso = pat[k];
                end
            end else begin
                if (!slv_pha) begin
                    k++;
                    if (k < 32) miso = pat[k];
                end else begin
                    if (k < 32) cap[k] = mosi;
                    k++;
                end
            end
        end
    end

    always @(ss_n) if (mon) ss_chg++;
    always @(negedge clk) if (mon) ss_or |= ~ss_n;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle(output bit ok);
        logic [7:0] s;
        ok = 0;
        for (int i = 0; i < 6000; i++) begin
            reg_rd(3'd1, s);
            if (!s[0]) begin ok = 1; break; end
        end
    endtask

    task automatic run_frame(input logic [7:0] ctl, input logic [7:0] cfg,
                             input logic [31:0] word, input logic [31:0] p, input bit poke);
        int n, half, pos;
        logic [31:0] exp_cap, exp_rx, got;
        logic [7:0]  s, b;
        bit ok;
        n    = (int'(ctl[5:4]) + 1) * 8;
        half = 24 >> cfg[5:4];
        exp_cap = '0; exp_rx = word;
        for (int j = 0; j < n; j++) begin
            pos = cfg[2] ? (32 - n + j) : (31 - j);
            exp_cap[j] = word[pos];
            exp_rx[pos] = p[j];
        end
        reg_wr(3'd1, cfg);
        reg_wr(3'd0, ctl);
        slv_pol = ctl[7]; slv_pha = ctl[6]; pat = p; cap = '0;
        k = 0; lead = 0; ss_chg = 0; ss_or = '0; gmin = 9999; gmax = 0; have_last = 0;
        miso = p[0];
        for (int i = 0; i < 3; i++) reg_wr(3'(2 + i), word[i*8 +: 8]);
        mon = 1'b1;
        reg_wr(3'd5, word[31:24]);
        #1 s = rd_data;
        addr = 3'd1;
        #1 s = rd_data;
        check(s[0] == 1'b1, "R3 busy after start", {31'd0, s[0]}, 32'd1);
        if (poke) begin
            repeat (60) @(negedge clk);
            reg_wr(3'd5, 8'h5A);
            reg_wr(3'd2, 8'hC3);
        end
        wait_idle(ok);
        check(ok, "R3 busy clears", {31'd0, ok}, 32'd1);
        got = '0;
        for (int i = 0; i < 4; i++) begin
            reg_rd(3'(2 + i), b);
            got[i*8 +: 8] = b;
        end
        check(got == exp_rx, poke ? "R11 word after ignored writes" : "R7 received word", got, exp_rx);
        repeat (100) @(negedge clk);
        mon = 1'b0;
        check(lead == n, poke ? "R11 no extra frame" : "R4 leading edges", lead, n);
        check(cap == exp_cap, cfg[2] ? "R5 LSB-first order" : "R6 mode/R5 MSB-first order", cap, exp_cap);
        check(gmin == half && gmax == half, "R8 half period", gmax, half);
        check(sclk == ctl[7], "R6 sclk idle level", sclk, ctl[7]);
        check(ss_or == (8'd1 << ctl[2:0]), ctl[3] ? "R10 manual line" : "R9 selected line", ss_or, 8'd1 << ctl[2:0]);
        check(ss_chg == (ctl[3] ? 0 : 2), ctl[3] ? "R10 select steady" : "R9 select toggles", ss_chg, ctl[3] ? 0 : 2);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 7; a++) begin
            reg_rd(3'(a), d);
            check(d == 8'd0, "R1 register reset", d, 0);
        end
        check(ss_n == 8'hFF && sclk == 1'b0 && mosi == 1'b0 && irq_out == 4'd0,
              "R1 pins at reset", {ss_n, 3'd0, sclk, 3'd0, mosi, irq_out}, {8'hFF, 16'd0});
    endtask

    task automatic t_regs;
        logic [7:0] d;
        reg_wr(3'd0, 8'hA5);
        reg_rd(3'd0, d);
        check(d == 8'hA5, "R2 control readback", d, 8'hA5);
        reg_wr(3'd1, 8'hFF);
        reg_rd(3'd1, d);
        check(d == 8'hFC, "R2 config readback, status read-only", d, 8'hFC);
        reg_wr(3'd6, 8'hFF);
        reg_rd(3'd6, d);
        check(d == 8'h01, "R2 manual select readback", d, 8'h01);
        reg_wr(3'd6, 8'h00);
        reg_wr(3'd0, 8'h00);
        reg_wr(3'd1, 8'h00);
    endtask

    task automatic t_frames;
        run_frame(8'h02, 8'h30, 32'hA5C3_1234, 32'h0000_00B6, 0);
        run_frame(8'hD3, 8'h24, 32'h3C96_F00D, 32'h0000_9E71, 0);
        run_frame(8'h65, 8'h10, 32'hF0E1_D2C3, 32'h00C5_A39B, 0);
        run_frame(8'hB7, 8'h04, 32'h8123_4567, 32'h6D2B_F418, 0);
    endtask

    task automatic t_busy_writes;
        run_frame(8'h31, 8'h00, 32'h1357_9BDF, 32'hCAFE_0F0F, 1);
    endtask

    task automatic t_manual;
        reg_wr(3'd0, 8'h0E);
        reg_wr(3'd6, 8'h01);
        repeat (2) @(negedge clk);
        check(ss_n == 8'hBF, "R10 manual assert", ss_n, 8'hBF);
        run_frame(8'h0E, 8'h30, 32'h7E00_0000, 32'h0000_0081, 0);
        reg_wr(3'd6, 8'h00);
        repeat (2) @(negedge clk);
        check(ss_n == 8'hFF, "R10 manual release", ss_n, 8'hFF);
        reg_wr(3'd0, 8'h00);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        reg_wr(3'd1, 8'h80);
        @(negedge clk) dev_int_n = 1'b0;
        repeat (4) @(negedge clk);
        reg_rd(3'd1, d);
        check(d[1] == 1'b1, "R12 interrupt status", d[1], 1);
        check(irq_out == 4'd0, "R12 disabled gating", irq_out, 0);
        reg_wr(3'd1, 8'h88);
        #1 check(irq_out == 4'b0100, "R12 route 2", irq_out, 4'b0100);
        reg_wr(3'd1, 8'h48);
        #1 check(irq_out == 4'b0010, "R12 route 1", irq_out, 4'b0010);
        @(negedge clk) dev_int_n = 1'b1;
        repeat (4) @(negedge clk);
        reg_rd(3'd1, d);
        check(d[1] == 1'b0 && irq_out == 4'd0, "R12 release", {d[1], irq_out}, 0);
        reg_wr(3'd1, 8'h00);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_frames();
        t_busy_writes();
        t_manual();
        t_irq();
        summary();
    end

endmodule